// File: doc/BRIEF.md
# Indirect Peripheral Bus Command Bridge

The bridge gives a host a window of four 64-bit registers through which it runs one transaction at a time on an internal 32-bit peripheral bus. The host loads a data word and then writes a command word. That single write carries the direction, the byte count and the peripheral address, and it starts the transfer at once. The block keeps no queue.

While the transfer is in flight the bridge is busy and ignores further command writes. When the peripheral answers, the bridge posts the outcome to a status register. A status read returns the outcome and empties the register. A read that fails still completes: it reports the done flag with an all-ones data field, so the host never has to decode an error code.

Top module: `ind_bus_bridge`

## Requirements
- R1: A host access selects its register with address bits [4:3]: 0 is command, 1 is reset, 2 is status, 3 is data. Higher address bits and bits [2:0] are ignored. The command and reset registers always read as zero.
- R2: A host write to the data register keeps bits [63:32] of the written word. A read of the data register returns that value in bits [63:32], with bits [31:0] zero.
- R3: A command write accepted while idle raises pb_req for exactly one cycle, in the cycle after the write. The bus fields are taken from the command word: pb_addr from bits [31:0], pb_size from bits [59:56], and pb_write high when bit 48 is clear (bit 48 set means read). These fields hold steady until the response.
- R4: A command whose size field is greater than 8 is rejected. No pb_req is raised and the status register keeps its previous value.
- R5: When a read completes without error, status becomes bit 11 (done) set, with pb_rdata in status bits [57:26]. pb_rdata carries the first returned byte in its bits [31:24]. All other status bits are zero.
- R6: When a read completes with pb_err set, status becomes bit 11 set and bits [57:26] all ones.
- R7: For a write, pb_wdata carries the data register, most-significant byte in bits [31:24]. On completion, status becomes bit 11 only, whether or not pb_err is set.
- R8: A host read of status returns its current value, and the register is zero from the next cycle. A response arriving in that same cycle takes precedence.
- R9: From an accepted command until its response, status reads zero. Command writes in that window are ignored: they raise no pb_req and do not change the fields of the transfer in flight.
- R10: Host writes to the status and reset registers change no state.
- R11: After reset, every register reads zero and pb_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 16 | Host byte address; bits [4:3] select the register |
| host_wdata | input | 64 | Host write word |
| host_rdata | output | 64 | Read word, valid in the cycle of a host read |
| pb_req | output | 1 | One-cycle request on the peripheral bus |
| pb_write | output | 1 | Direction of the transfer, 1 for a write |
| pb_addr | output | 32 | Peripheral byte address |
| pb_size | output | 4 | Transfer size in bytes, 0 to 8 |
| pb_wdata | output | 32 | Write data, first byte in [31:24] |
| pb_resp | input | 1 | One-cycle response strobe from the peripheral |
| pb_err | input | 1 | Transfer error, qualified by pb_resp |
| pb_rdata | input | 32 | Read data, qualified by pb_resp |

## Verification
The bench sweeps every value of the 4-bit size field against both directions and both response outcomes. The boundary between 8 and 9 is the one most likely to be off by one: a design that got it wrong would either launch a 9-byte transfer or reject a legal 8-byte one. A rejected command issued while an unread result is waiting must leave that result intact, because a bridge that cleared status on every command write would lose it.

The bench also writes a second command mid-transfer. A busy guard that is missing would retarget the bus address or post the wrong result. The status register is read twice in a row to catch a clear-on-read that never fires. Failed reads and failed writes are checked separately, since a design that shares one completion path would leak all-ones data into the status of a write.

// File: rtl/bib_pkg.sv
package bib_pkg;
    localparam int HOST_W       = 64;
    localparam int PADDR_W      = 32;
    localparam int PDATA_W      = 32;
    localparam int SIZE_W       = 4;
    localparam int MAX_BYTES    = 8;
    localparam int CMD_RD_BIT   = 48;
    localparam int CMD_SIZE_LO  = 56;
    localparam int STAT_DONE    = 11;
    localparam int STAT_DATA_LO = 26;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_RST  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } bib_sel_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ISSUE = 2'd1,
        ENG_WAIT  = 2'd2
    } bib_state_e;

    typedef struct packed {
        logic               is_read;
        logic [SIZE_W-1:0]  size;
        logic [PADDR_W-1:0] addr;
    } bib_cmd_t;

    function automatic bib_cmd_t unpack_cmd(input logic [HOST_W-1:0] w);
        bib_cmd_t c;
        c.is_read = w[CMD_RD_BIT];
        c.size    = w[CMD_SIZE_LO +: SIZE_W];
        c.addr    = w[PADDR_W-1:0];
        return c;
    endfunction

    function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
        return 32'(sz) <= MAX_BYTES;
    endfunction

    function automatic logic [HOST_W-1:0] make_status(input logic is_read,
                                                      input logic err,
                                                      input logic [PDATA_W-1:0] rd);
        logic [HOST_W-1:0] s;
        s = '0;
        s[STAT_DONE] = 1'b1;
        if (is_read)
            s[STAT_DATA_LO +: PDATA_W] = err ? {PDATA_W{1'b1}} : rd;
        return s;
    endfunction
endpackage

// File: rtl/bib_regsel.sv
module bib_regsel
    import bib_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    output bib_sel_e          sel,
    output logic              cmd_wr,
    output logic              data_wr,
    output logic              stat_rd
);
    localparam int SEL_LO = 3;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{host_addr[ADDR_W-1:SEL_LO+2], host_addr[SEL_LO-1:0]};

    always_comb begin
        sel     = bib_sel_e'(host_addr[SEL_LO +: 2]);
        cmd_wr  = host_valid &&  host_write && (sel == SEL_CMD);
        data_wr = host_valid &&  host_write && (sel == SEL_DATA);
        stat_rd = host_valid && !host_write && (sel == SEL_STAT);
    end
endmodule

// File: rtl/bib_cmd_engine.sv
module bib_cmd_engine
    import bib_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr,
    input  bib_cmd_t           cmd_in,
    input  logic [PDATA_W-1:0] data_q,
    input  logic               stat_rd,
    input  logic               pb_resp,
    input  logic               pb_err,
    input  logic [PDATA_W-1:0] pb_rdata,
    output logic               pb_req,
    output logic               pb_write,
    output logic [PADDR_W-1:0] pb_addr,
    output logic [SIZE_W-1:0]  pb_size,
    output logic [PDATA_W-1:0] pb_wdata,
    output logic [HOST_W-1:0]  stat_q
);
    bib_state_e         state_q;
    bib_cmd_t           held_q;
    logic [PDATA_W-1:0] wdata_q;
    logic               accept;
    logic               in_flight;

    assign in_flight = (state_q != ENG_IDLE);
    assign accept    = cmd_wr && !in_flight && size_legal(cmd_in.size);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            held_q  <= '0;
            wdata_q <= '0;
            stat_q  <= '0;
        end else begin
            case (state_q)
                ENG_IDLE:  if (accept) state_q <= ENG_ISSUE;
                ENG_ISSUE: state_q <= pb_resp ? ENG_IDLE : ENG_WAIT;
                ENG_WAIT:  if (pb_resp) state_q <= ENG_IDLE;
                default:   state_q <= ENG_IDLE;
            endcase

            if (accept) begin
                held_q  <= cmd_in;
                wdata_q <= data_q;
            end

            if (accept)
                stat_q <= '0;
            else if (in_flight && pb_resp)
                stat_q <= make_status(held_q.is_read, pb_err, pb_rdata);
            else if (stat_rd)
                stat_q <= '0;
        end
    end

    assign pb_req   = (state_q == ENG_ISSUE);
    assign pb_write = !held_q.is_read;
    assign pb_addr  = held_q.addr;
    assign pb_size  = held_q.size;
    assign pb_wdata = wdata_q;
endmodule

// File: rtl/ind_bus_bridge.sv
module ind_bus_bridge
    import bib_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_valid,
    input  logic                 host_write,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [HOST_W-1:0]    host_wdata,
    output logic [HOST_W-1:0]    host_rdata,
    output logic                 pb_req,
    output logic                 pb_write,
    output logic [PADDR_W-1:0]   pb_addr,
    output logic [SIZE_W-1:0]    pb_size,
    output logic [PDATA_W-1:0]   pb_wdata,
    input  logic                 pb_resp,
    input  logic                 pb_err,
    input  logic [PDATA_W-1:0]   pb_rdata
);
    bib_sel_e           sel;
    logic               cmd_wr, data_wr, stat_rd;
    logic [PDATA_W-1:0] data_q;
    logic [HOST_W-1:0]  stat_q;
    bib_cmd_t           cmd_in;

    bib_regsel #(.ADDR_W(ADDR_W)) u_sel (
        .host_valid (host_valid),
        .host_write (host_write),
        .host_addr  (host_addr),
        .sel        (sel),
        .cmd_wr     (cmd_wr),
        .data_wr    (data_wr),
        .stat_rd    (stat_rd)
    );

    assign cmd_in = unpack_cmd(host_wdata);

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (data_wr)
            data_q <= host_wdata[HOST_W-1 -: PDATA_W];
    end

    bib_cmd_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_in   (cmd_in),
        .data_q   (data_q),
        .stat_rd  (stat_rd),
        .pb_resp  (pb_resp),
        .pb_err   (pb_err),
        .pb_rdata (pb_rdata),
        .pb_req   (pb_req),
        .pb_write (pb_write),
        .pb_addr  (pb_addr),
        .pb_size  (pb_size),
        .pb_wdata (pb_wdata),
        .stat_q   (stat_q)
    );

    always_comb begin
        host_rdata = '0;
        if (host_valid && !host_write) begin
            case (sel)
                SEL_STAT: host_rdata = stat_q;
                SEL_DATA: host_rdata = {data_q, {(HOST_W-PDATA_W){1'b0}}};
                default:  host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bib_checker.sv
module bib_checker
    import bib_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               host_valid,
    input logic               host_write,
    input logic [ADDR_W-1:0]  host_addr,
    input logic [HOST_W-1:0]  host_wdata,
    input logic               pb_req,
    input logic [PADDR_W-1:0] pb_addr,
    input logic               pb_resp,
    input logic [HOST_W-1:0]  stat_q
);
    logic outstanding;
    logic is_cmd_wr, is_stat_rd;

    assign is_cmd_wr  = host_valid && host_write && (host_addr[4:3] == 2'd0);
    assign is_stat_rd = host_valid && !host_write && (host_addr[4:3] == 2'd2);

    always_ff @(posedge clk) begin
        if (rst)
            outstanding <= 1'b0;
        else if (pb_req && !pb_resp)
            outstanding <= 1'b1;
        else if (pb_resp)
            outstanding <= 1'b0;
    end

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pb_req |=> !pb_req);

    // R9
    no_req_inflight_chk: assert property (@(posedge clk) disable iff (rst)
        pb_req |-> !outstanding);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (outstanding && !pb_req) |-> $stable(pb_addr));

    // R4
    oversize_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cmd_wr && (host_wdata[59:56] > 4'd8)) |=> !pb_req);

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (is_stat_rd && !pb_resp) |=> (stat_q == '0));

    // R5
    resp_done_chk: assert property (@(posedge clk) disable iff (rst)
        (pb_resp && outstanding) |=> stat_q[STAT_DONE]);
endmodule

bind ind_bus_bridge bib_checker #(.ADDR_W(ADDR_W)) u_bib_chk (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .pb_req     (pb_req),
    .pb_addr    (pb_addr),
    .pb_resp    (pb_resp),
    .stat_q     (stat_q)
);

// File: tb/ind_bus_bridge_bench.sv
module ind_bus_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [15:0] host_addr  = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        pb_req, pb_write;
    logic [31:0] pb_addr, pb_wdata;
    logic [3:0]  pb_size;
    logic        pb_resp = 1'b0;
    logic        pb_err  = 1'b0;
    logic [31:0] pb_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [15:0] A_CMD  = 16'h0200;
    localparam logic [15:0] A_RST  = 16'h0408;
    localparam logic [15:0] A_STAT = 16'h0010;
    localparam logic [15:0] A_DATA = 16'hF01B;

    always #2 clk = ~clk;

    ind_bus_bridge u_ind_bus_bridge (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pb_req(pb_req), .pb_write(pb_write), .pb_addr(pb_addr), .pb_size(pb_size),
        .pb_wdata(pb_wdata), .pb_resp(pb_resp), .pb_err(pb_err), .pb_rdata(pb_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [15:0] a, input logic [63:0] d);
        host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 0; host_write = 0; host_wdata = '0;
    endtask

    task automatic hr(input logic [15:0] a, output logic [63:0] d);
        host_valid = 1; host_write = 0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_valid = 0;
    endtask

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        return a ^ 32'hA5C3_0F1E;
    endfunction

    function automatic logic [63:0] mk_cmd(input bit rd, input logic [3:0] sz,
                                           input logic [31:0] a);
        logic [63:0] c;
        c = 64'h0000_5A00_0000_0000;
        c[59:56] = sz;
        c[48] = rd;
        c[31:0] = a;
        return c;
    endfunction

    function automatic logic [63:0] exp_stat(input bit rd, input bit err,
                                             input logic [31:0] a);
        logic [63:0] s;
        s = 64'h800;
        if (rd) s = s | ({32'h0, (err ? 32'hFFFF_FFFF : model_rd(a))} << 26);
        return s;
    endfunction

    task automatic respond(input bit err, input logic [31:0] a);
        pb_resp = 1; pb_err = err; pb_rdata = model_rd(a);
        @(negedge clk);
        pb_resp = 0; pb_err = 0; pb_rdata = '0;
    endtask

    task automatic run_cmd(input bit rd, input logic [3:0] sz, input logic [31:0] a,
                           input bit err, input logic [31:0] dreg, input bit peek);
        logic [63:0] v;
        hw(A_CMD, mk_cmd(rd, sz, a));
        if (sz > 4'd8) begin
            chk(pb_req == 0, "R4 no request", 64'(pb_req), 0);
            @(negedge clk);
            chk(pb_req == 0, "R4 still no request", 64'(pb_req), 0);
            hr(A_STAT, v);
            chk(v == 0, "R4 status untouched", v, 0);
            return;
        end
        chk(pb_req == 1, "R3 request raised", 64'(pb_req), 1);
        chk(pb_addr == a, "R3 address", 64'(pb_addr), 64'(a));
        chk(pb_size == sz, "R3 size", 64'(pb_size), 64'(sz));
        chk(pb_write == !rd, "R3 direction", 64'(pb_write), 64'(!rd));
        if (!rd) chk(pb_wdata == dreg, "R7 write data", 64'(pb_wdata), 64'(dreg));
        @(negedge clk);
        chk(pb_req == 0, "R3 single pulse", 64'(pb_req), 0);
        if (peek) begin
            hr(A_STAT, v);
            chk(v == 0, "R9 status zero in flight", v, 0);
        end
        respond(err, a);
        hr(A_STAT, v);
        chk(v == exp_stat(rd, err, a), rd ? (err ? "R6 failed read" : "R5 read status")
                                          : "R7 write status", v, exp_stat(rd, err, a));
        hr(A_STAT, v);
        chk(v == 0, "R8 cleared on read", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [31:0] dreg;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R11 reset state, R1 decode
        chk(pb_req == 0, "R11 pb_req low", 64'(pb_req), 0);
        hr(A_CMD, v);  chk(v == 0, "R11 command reads zero", v, 0);
        hr(A_RST, v);  chk(v == 0, "R11 reset reg reads zero", v, 0);
        hr(A_STAT, v); chk(v == 0, "R11 status zero", v, 0);
        hr(A_DATA, v); chk(v == 0, "R11 data zero", v, 0);

        // R2 data register
        hw(A_DATA, 64'hDEAD_BEEF_1234_5678);
        hr(A_DATA, v);
        chk(v == 64'hDEAD_BEEF_0000_0000, "R2 data upper half", v, 64'hDEAD_BEEF_0000_0000);
        hr(16'h0018, v);
        chk(v == 64'hDEAD_BEEF_0000_0000, "R1 alias decode", v, 64'hDEAD_BEEF_0000_0000);
        hr(A_CMD, v);
        chk(v == 0, "R1 command reads zero", v, 0);
        dreg = 32'hDEAD_BEEF;

        // Sweep size x direction x error
        for (int sz = 0; sz < 16; sz++)
            for (int rd = 0; rd < 2; rd++)
                for (int e = 0; e < 2; e++) begin
                    dreg = 32'h1000_0001 * (sz + 1) + 32'(rd * 7 + e);
                    hw(A_DATA, {dreg, 32'hFFFF_FFFF});
                    run_cmd(rd[0], sz[3:0], 32'h8000_0000 | 32'(sz * 64 + rd * 16 + e),
                            e[0], dreg, (sz == 3));
                end

        // R4 rejected command keeps pending result
        run_cmd(1'b1, 4'd8, 32'h0000_1234, 1'b0, dreg, 1'b0);
        hw(A_CMD, mk_cmd(1'b1, 4'd4, 32'h0000_0042));
        @(negedge clk);
        respond(1'b0, 32'h0000_0042);
        hw(A_CMD, mk_cmd(1'b0, 4'd9, 32'h0000_0099));
        chk(pb_req == 0, "R4 oversize rejected", 64'(pb_req), 0);
        hr(A_STAT, v);
        chk(v == exp_stat(1, 0, 32'h42), "R4 pending status kept", v, exp_stat(1, 0, 32'h42));

        // R10 writes to status and reset ignored
        hw(A_CMD, mk_cmd(1'b0, 4'd2, 32'h0000_0077));
        @(negedge clk);
        respond(1'b1, 32'h77);
        hw(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF);
        hw(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
        hr(A_STAT, v);
        chk(v == 64'h800, "R10 status write ignored", v, 64'h800);
        hr(A_DATA, v);
        chk(v == {dreg, 32'h0}, "R10 reset write ignored", v, {dreg, 32'h0});

        // R9 command while busy ignored
        hw(A_CMD, mk_cmd(1'b1, 4'd4, 32'h0000_0AAA));
        chk(pb_req == 1, "R9 first request", 64'(pb_req), 1);
        hw(A_CMD, mk_cmd(1'b1, 4'd4, 32'h0000_0BBB));
        chk(pb_req == 0, "R9 no second request", 64'(pb_req), 0);
        chk(pb_addr == 32'h0AAA, "R9 address held", 64'(pb_addr), 64'h0AAA);
        @(negedge clk);
        chk(pb_req == 0, "R9 still no request", 64'(pb_req), 0);
        respond(1'b0, 32'h0AAA);
        hr(A_STAT, v);
        chk(v == exp_stat(1, 0, 32'h0AAA), "R9 first result posted", v, exp_stat(1, 0, 32'h0AAA));
        @(negedge clk);
        chk(pb_req == 0, "R9 dropped command stays dropped", 64'(pb_req), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule